// File: doc/BRIEF.md
# Sector-Organized Read Buffer Controller

This block sits between a processor and a slow main store. It keeps copies of recently used store data so that most processor reads complete one cycle after they are presented. Software sees no difference from a plain store: there are no control registers and no special operations. The processor asks for 1 to 8 bytes inside one aligned doubleword. The block answers with that whole doubleword, or it holds the processor off while it fetches a 64-byte block from main store as a stream of eight doublewords.

The capacity of 32768 bytes is split into eight sectors. Each sector is tagged with one aligned 4096-byte region of the address space. Validity is kept per 64-byte block, so a miss brings in only the block that holds the requested doubleword. A new region takes over the least recently read sector and starts with every block in that sector invalid. Stores always go through to main store. The buffered copy is patched only when the block is already present, and a store never allocates.

Top module: `sector_buffer_cache`

## Requirements
- R1: After reset, `cpu_ready` is high and `cpu_ack` and `mem_req` are low. Every sector is empty, so the first read of any address misses.
- R2: A read that hits is acknowledged exactly one cycle after it is accepted, with no memory request. `cpu_rdata` is the aligned doubleword that holds the address, with the byte at offset i of that doubleword in bits 8i+7:8i.
- R3: A read whose sector is present but whose block is invalid holds `mem_req` high with `mem_we` low and the block-aligned address (low 6 bits zero) until `mem_gnt`. The other blocks of that sector stay valid.
- R4: After the grant, the block arrives as eight doublewords in ascending address order, one on each cycle that `mem_rvalid` is high, with idle cycles allowed between them. `cpu_ack` rises in the cycle after the eighth beat and carries the requested doubleword. The block is then valid.
- R5: On a read whose region is in no sector, the least recently read sector is reassigned and all 64 of its block valid bits are cleared before the fill. Every accepted read makes its sector the most recent one; writes leave the ordering unchanged. After reset, the sectors are taken in the order 0, 1, 2 and so on.
- R6: An access with a length of 0, a length above 8, or an offset plus length above 8 is acknowledged in the next cycle with `cpu_err` high. It causes no memory request and changes no buffer state.
- R7: A write holds one memory write request at the doubleword-aligned address until `mem_gnt`. Byte enable bit i is set exactly for the offsets from addr[2:0] up to addr[2:0]+len-1, and byte i of `cpu_wdata` sits in bits 8i+7:8i. `cpu_ack` follows in the cycle after the grant.
- R8: A write to a valid block also updates the enabled bytes of the buffered copy. A write to an invalid block or to an absent region allocates nothing.
- R9: `cpu_ready` is low from the acceptance of a missing read or of a write until its acknowledge. A request is accepted only on a clock edge where both `cpu_req` and `cpu_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, taken when `cpu_ready` is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 24 | Byte address of the first byte |
| cpu_len | input | 4 | Byte count, 1 to 8 |
| cpu_wdata | input | 64 | Write data in doubleword lane positions |
| cpu_ready | output | 1 | Block can take a new request |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_err | output | 1 | Completion was a rejected access |
| cpu_rdata | output | 64 | Doubleword for a completed read |
| mem_req | output | 1 | Main-store request pending |
| mem_we | output | 1 | Pending request is a write |
| mem_addr | output | 24 | Block address for reads, doubleword address for writes |
| mem_be | output | 8 | Byte enables of the write |
| mem_wdata | output | 64 | Write data |
| mem_gnt | input | 1 | Main store has taken the request |
| mem_rvalid | input | 1 | A fill doubleword is present |
| mem_rdata | input | 64 | Fill doubleword |

## Verification
The assertions assume that main store drives `mem_rvalid` only after it has granted a read, and for exactly eight beats. They also assume that `cpu_req` is honoured only while `cpu_ready` is high. The bench acts as main store inside each access task. It grants after a chosen delay and streams the eight beats, with or without a bubble, only after its own grant. It also raises `cpu_req` only at points where its model says the block is idle.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RDREQ = 2'd1,
        ST_FILL  = 2'd2,
        ST_WRREQ = 2'd3
    } ctl_state_e;
endpackage

// File: rtl/sbc_access_check.sv
module sbc_access_check #(
    parameter int DW_BYTES = 8,
    localparam int OFF_W = $clog2(DW_BYTES),
    localparam int LEN_W = $clog2(DW_BYTES) + 1
) (
    input  logic [OFF_W-1:0]    off,
    input  logic [LEN_W-1:0]    len,
    output logic                bad,
    output logic [DW_BYTES-1:0] be
);
    logic [LEN_W:0] span;

    always_comb begin
        span = {1'b0, len} + (LEN_W+1)'(off);
        bad  = (len == '0) || (len > LEN_W'(DW_BYTES)) || (span > (LEN_W+1)'(DW_BYTES));
    end

    for (genvar i = 0; i < DW_BYTES; i++) begin : g_lane
        assign be[i] = ((LEN_W+1)'(i) >= (LEN_W+1)'(off)) && ((LEN_W+1)'(i) < span);
    end
endmodule

// File: rtl/sbc_data_store.sv
module sbc_data_store #(
    parameter int DEPTH  = 4096,
    parameter int DATA_W = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int NB    = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NB-1:0]     wr_be
);
    logic [DATA_W-1:0] mem_r [DEPTH];

    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_data <= mem_r[rd_idx];
        end
        if (wr_en) begin
            for (int b = 0; b < NB; b++) begin
                if (wr_be[b]) begin
                    mem_r[wr_idx][8*b +: 8] <= wr_data[8*b +: 8];
                end
            end
        end
    end
endmodule

// File: rtl/sbc_directory.sv
module sbc_directory #(
    parameter int SECTORS = 8,
    parameter int TAG_W   = 12,
    parameter int BLOCKS  = 64,
    localparam int SEC_W  = $clog2(SECTORS),
    localparam int BLK_W  = $clog2(BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic [BLK_W-1:0] lk_blk,
    output logic             sector_hit,
    output logic [SEC_W-1:0] hit_sec,
    output logic             blk_valid,
    output logic [SEC_W-1:0] victim_sec,
    input  logic             alloc_en,
    input  logic [SEC_W-1:0] alloc_sec,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic             touch_en,
    input  logic [SEC_W-1:0] touch_sec,
    input  logic             setv_en,
    input  logic [SEC_W-1:0] setv_sec,
    input  logic [BLK_W-1:0] setv_blk
);
    typedef struct packed {
        logic [SECTORS-1:0]            sv;
        logic [SECTORS-1:0][TAG_W-1:0] tag;
        logic [SECTORS-1:0][BLOCKS-1:0] bv;
        logic [SECTORS-1:0][SEC_W-1:0] age;
    } dir_t;

    dir_t dir_q, dir_d;
    logic [SECTORS-1:0] hit_vec;
    logic [SECTORS-1:0] oldest_vec;

    for (genvar i = 0; i < SECTORS; i++) begin : g_sec
        assign hit_vec[i]    = dir_q.sv[i] && (dir_q.tag[i] == lk_tag);
        assign oldest_vec[i] = (dir_q.age[i] == SEC_W'(SECTORS-1));
    end

    always_comb begin
        hit_sec    = '0;
        victim_sec = '0;
        for (int i = 0; i < SECTORS; i++) begin
            if (hit_vec[i])    hit_sec    = SEC_W'(i);
            if (oldest_vec[i]) victim_sec = SEC_W'(i);
        end
        sector_hit = |hit_vec;
        blk_valid  = dir_q.bv[hit_sec][lk_blk];
    end

    always_comb begin
        dir_d = dir_q;
        if (alloc_en) begin
            dir_d.sv[alloc_sec]  = 1'b1;
            dir_d.tag[alloc_sec] = alloc_tag;
            dir_d.bv[alloc_sec]  = '0;
        end
        if (setv_en) begin
            dir_d.bv[setv_sec][setv_blk] = 1'b1;
        end
        if (touch_en) begin
            for (int i = 0; i < SECTORS; i++) begin
                if (SEC_W'(i) == touch_sec) begin
                    dir_d.age[i] = '0;
                end else if (dir_q.age[i] < dir_q.age[touch_sec]) begin
                    dir_d.age[i] = dir_q.age[i] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q.sv  <= '0;
            dir_q.tag <= '0;
            dir_q.bv  <= '0;
            for (int i = 0; i < SECTORS; i++) begin
                dir_q.age[i] <= SEC_W'(SECTORS-1-i);
            end
        end else begin
            dir_q <= dir_d;
        end
    end

    // R5
    tag_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R5
    single_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest_vec) == 1);

    // R4
    valid_in_owned_sector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        setv_en |-> dir_q.sv[setv_sec]);
endmodule

// File: rtl/sector_buffer_cache.sv
module sector_buffer_cache
    import sbc_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 64,
    parameter int CAP_BYTES = 32768,
    parameter int SEC_BYTES = 4096,
    parameter int BLK_BYTES = 64,
    localparam int DW_BYTES = DATA_W / 8,
    localparam int LEN_W    = $clog2(DW_BYTES) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_req,
    input  logic                cpu_we,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [LEN_W-1:0]    cpu_len,
    input  logic [DATA_W-1:0]   cpu_wdata,
    output logic                cpu_ready,
    output logic                cpu_ack,
    output logic                cpu_err,
    output logic [DATA_W-1:0]   cpu_rdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DW_BYTES-1:0] mem_be,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic                mem_gnt,
    input  logic                mem_rvalid,
    input  logic [DATA_W-1:0]   mem_rdata
);
    localparam int OFF_W     = $clog2(DW_BYTES);
    localparam int BEATS     = BLK_BYTES / DW_BYTES;
    localparam int BEAT_W    = $clog2(BEATS);
    localparam int BLK_OFF_W = $clog2(BLK_BYTES);
    localparam int SEC_OFF_W = $clog2(SEC_BYTES);
    localparam int BLOCKS    = SEC_BYTES / BLK_BYTES;
    localparam int BLK_W     = $clog2(BLOCKS);
    localparam int SECTORS   = CAP_BYTES / SEC_BYTES;
    localparam int SEC_W     = $clog2(SECTORS);
    localparam int TAG_W     = ADDR_W - SEC_OFF_W;
    localparam int DEPTH     = CAP_BYTES / DW_BYTES;
    localparam int IDX_W     = SEC_W + BLK_W + BEAT_W;

    typedef struct packed {
        ctl_state_e           st;
        logic [ADDR_W-1:0]    addr;
        logic [SEC_W-1:0]     sec;
        logic [BEAT_W-1:0]    cnt;
        logic                 ack;
        logic                 err;
        logic                 use_fill;
        logic [DATA_W-1:0]    fill;
        logic [DATA_W-1:0]    wdata;
        logic [DW_BYTES-1:0]  be;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic [TAG_W-1:0]    req_tag;
    logic [BLK_W-1:0]    req_blk, q_blk;
    logic [BEAT_W-1:0]   req_beat, q_beat;
    logic                acc_bad;
    logic [DW_BYTES-1:0] acc_be;
    logic                sector_hit, blk_valid;
    logic [SEC_W-1:0]    hit_sec, victim_sec;
    logic                alloc_en, touch_en, setv_en;
    logic [SEC_W-1:0]    touch_sec;
    logic                rd_en, wr_en;
    logic [IDX_W-1:0]    rd_idx, wr_idx;
    logic [DATA_W-1:0]   wr_data, store_rdata;
    logic [DW_BYTES-1:0] wr_be;

    assign req_tag  = cpu_addr[ADDR_W-1:SEC_OFF_W];
    assign req_blk  = cpu_addr[SEC_OFF_W-1:BLK_OFF_W];
    assign req_beat = cpu_addr[BLK_OFF_W-1:OFF_W];
    assign q_blk    = ctl_q.addr[SEC_OFF_W-1:BLK_OFF_W];
    assign q_beat   = ctl_q.addr[BLK_OFF_W-1:OFF_W];

    sbc_access_check #(.DW_BYTES(DW_BYTES)) u_check (
        .off (cpu_addr[OFF_W-1:0]),
        .len (cpu_len),
        .bad (acc_bad),
        .be  (acc_be)
    );

    sbc_directory #(.SECTORS(SECTORS), .TAG_W(TAG_W), .BLOCKS(BLOCKS)) u_dir (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_tag     (req_tag),
        .lk_blk     (req_blk),
        .sector_hit (sector_hit),
        .hit_sec    (hit_sec),
        .blk_valid  (blk_valid),
        .victim_sec (victim_sec),
        .alloc_en   (alloc_en),
        .alloc_sec  (victim_sec),
        .alloc_tag  (req_tag),
        .touch_en   (touch_en),
        .touch_sec  (touch_sec),
        .setv_en    (setv_en),
        .setv_sec   (ctl_q.sec),
        .setv_blk   (q_blk)
    );

    sbc_data_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rd_en   (rd_en),
        .rd_idx  (rd_idx),
        .rd_data (store_rdata),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .wr_be   (wr_be)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.ack = 1'b0;
        ctl_d.err = 1'b0;
        alloc_en  = 1'b0;
        touch_en  = 1'b0;
        touch_sec = hit_sec;
        setv_en   = 1'b0;
        rd_en     = 1'b0;
        rd_idx    = {hit_sec, req_blk, req_beat};
        wr_en     = 1'b0;
        wr_idx    = {hit_sec, req_blk, req_beat};
        wr_data   = cpu_wdata;
        wr_be     = acc_be;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (acc_bad) begin
                        ctl_d.ack = 1'b1;
                        ctl_d.err = 1'b1;
                    end else if (cpu_we) begin
                        ctl_d.st    = ST_WRREQ;
                        ctl_d.addr  = cpu_addr;
                        ctl_d.wdata = cpu_wdata;
                        ctl_d.be    = acc_be;
                        wr_en       = sector_hit && blk_valid;
                    end else begin
                        touch_en   = 1'b1;
                        ctl_d.addr = cpu_addr;
                        if (sector_hit && blk_valid) begin
                            rd_en          = 1'b1;
                            ctl_d.ack      = 1'b1;
                            ctl_d.use_fill = 1'b0;
                        end else begin
                            ctl_d.st  = ST_RDREQ;
                            ctl_d.cnt = '0;
                            if (sector_hit) begin
                                ctl_d.sec = hit_sec;
                            end else begin
                                alloc_en  = 1'b1;
                                touch_sec = victim_sec;
                                ctl_d.sec = victim_sec;
                            end
                        end
                    end
                end
            end
            ST_RDREQ: begin
                mem_req  = 1'b1;
                mem_addr = {ctl_q.addr[ADDR_W-1:BLK_OFF_W], BLK_OFF_W'(0)};
                if (mem_gnt) ctl_d.st = ST_FILL;
            end
            ST_FILL: begin
                wr_idx  = {ctl_q.sec, q_blk, ctl_q.cnt};
                wr_data = mem_rdata;
                wr_be   = '1;
                if (mem_rvalid) begin
                    wr_en     = 1'b1;
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == q_beat) ctl_d.fill = mem_rdata;
                    if (ctl_q.cnt == BEAT_W'(BEATS-1)) begin
                        setv_en        = 1'b1;
                        ctl_d.ack      = 1'b1;
                        ctl_d.use_fill = 1'b1;
                        ctl_d.st       = ST_IDLE;
                    end
                end
            end
            ST_WRREQ: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {ctl_q.addr[ADDR_W-1:OFF_W], OFF_W'(0)};
                if (mem_gnt) begin
                    ctl_d.ack = 1'b1;
                    ctl_d.st  = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cpu_ready = (ctl_q.st == ST_IDLE);
    assign cpu_ack   = ctl_q.ack;
    assign cpu_err   = ctl_q.err;
    assign cpu_rdata = ctl_q.use_fill ? ctl_q.fill : store_rdata;
    assign mem_be    = ctl_q.be;
    assign mem_wdata = ctl_q.wdata;

    // R9
    accept_reacts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready) |=> (cpu_ack || mem_req));

    // R9
    ack_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> cpu_ready);

    // R6
    err_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_err |-> cpu_ack);

    // R3
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R4
    beat_in_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid |-> (ctl_q.st == ST_FILL));
endmodule

// File: tb/sector_buffer_cache_tb.sv
module sector_buffer_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic [3:0]  cpu_len = '0;
    logic [63:0] cpu_wdata = '0;
    logic        cpu_ready, cpu_ack, cpu_err;
    logic [63:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [23:0] mem_addr;
    logic [7:0]  mem_be;
    logic [63:0] mem_wdata;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    int          tag_m [8];
    bit          bv_m [8][64];
    int          order [$];
    logic [63:0] mem_m [int];

    always #4 clk = ~clk;

    sector_buffer_cache dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_len(cpu_len),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_ack(cpu_ack), .cpu_err(cpu_err),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mem_rd(int dwa);
        if (mem_m.exists(dwa)) return mem_m[dwa];
        return {32'(dwa) ^ 32'hA5C3_0000, ~32'(dwa * 7)};
    endfunction

    function automatic int find_sec(int tag);
        for (int i = 0; i < 8; i++) if (tag_m[i] == tag) return i;
        return -1;
    endfunction

    task automatic touch(int s);
        for (int i = 0; i < order.size(); i++) begin
            if (order[i] == s) begin
                order.delete(i);
                break;
            end
        end
        order.push_front(s);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk("R9", "idle ack", 64'(cpu_ack), 64'd0);
            chk("R9", "idle mem_req", 64'(mem_req), 64'd0);
            chk("R9", "idle ready", 64'(cpu_ready), 64'd1);
        end
    endtask

    task automatic grant(int wait_n, string req);
        for (int k = 0; k < wait_n; k++) begin
            @(negedge clk);
            chk(req, "req held", 64'(mem_req), 64'd1);
            chk(req, "no early ack", 64'(cpu_ack), 64'd0);
        end
        mem_gnt = 1'b1;
        @(negedge clk);
        mem_gnt = 1'b0;
    endtask

    task automatic access(bit we, int addr, int len, logic [63:0] wd, int gw, bit gap, string req);
        int off = addr % 8;
        bit bad = (len == 0) || (len > 8) || (off + len > 8);
        int dwa = addr / 8;
        int tag = addr / 4096;
        int blk = (addr / 64) % 64;
        logic [7:0] be;
        for (int i = 0; i < 8; i++) be[i] = (i >= off) && (i < off + len);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = 24'(addr); cpu_len = 4'(len); cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        if (bad) begin
            chk(req, "err ack", 64'(cpu_ack), 64'd1);
            chk(req, "err flag", 64'(cpu_err), 64'd1);
            chk(req, "err no mem", 64'(mem_req), 64'd0);
            return;
        end
        if (we) begin
            chk(req, "wr ack low", 64'(cpu_ack), 64'd0);
            chk(req, "wr ready low", 64'(cpu_ready), 64'd0);
            chk(req, "wr req", 64'(mem_req), 64'd1);
            chk(req, "wr we", 64'(mem_we), 64'd1);
            chk(req, "wr addr", 64'(mem_addr), 64'(addr & ~7));
            chk(req, "wr be", 64'(mem_be), 64'(be));
            chk(req, "wr data", mem_wdata, wd);
            grant(gw, req);
            chk(req, "wr ack", 64'(cpu_ack), 64'd1);
            chk(req, "wr no err", 64'(cpu_err), 64'd0);
            chk(req, "wr req drop", 64'(mem_req), 64'd0);
            begin
                logic [63:0] nv = mem_rd(dwa);
                for (int i = 0; i < 8; i++) if (be[i]) nv[8*i +: 8] = wd[8*i +: 8];
                mem_m[dwa] = nv;
            end
        end else begin
            int s = find_sec(tag);
            bit hit = (s >= 0) && bv_m[(s < 0) ? 0 : s][blk];
            if (s < 0) begin
                s = order[$];
                tag_m[s] = tag;
                for (int b = 0; b < 64; b++) bv_m[s][b] = 1'b0;
            end
            touch(s);
            if (hit) begin
                chk(req, "hit ack", 64'(cpu_ack), 64'd1);
                chk(req, "hit no err", 64'(cpu_err), 64'd0);
                chk(req, "hit data", cpu_rdata, mem_rd(dwa));
                chk(req, "hit no mem", 64'(mem_req), 64'd0);
            end else begin
                int base = addr & ~63;
                chk(req, "miss ack low", 64'(cpu_ack), 64'd0);
                chk(req, "miss ready low", 64'(cpu_ready), 64'd0);
                chk(req, "miss req", 64'(mem_req), 64'd1);
                chk(req, "miss we", 64'(mem_we), 64'd0);
                chk(req, "miss addr", 64'(mem_addr), 64'(base));
                grant(gw, req);
                chk(req, "req drop", 64'(mem_req), 64'd0);
                for (int b = 0; b < 8; b++) begin
                    if (gap && b == 3) begin
                        @(negedge clk);
                        chk("R4", "bubble ack", 64'(cpu_ack), 64'd0);
                    end
                    mem_rvalid = 1'b1;
                    mem_rdata = mem_rd(base / 8 + b);
                    @(negedge clk);
                    mem_rvalid = 1'b0;
                    mem_rdata = '0;
                    if (b < 7) chk("R4", "fill ack low", 64'(cpu_ack), 64'd0);
                end
                chk("R4", "fill ack", 64'(cpu_ack), 64'd1);
                chk("R4", "fill no err", 64'(cpu_err), 64'd0);
                chk("R4", "fill data", cpu_rdata, mem_rd(dwa));
                chk("R9", "ready back", 64'(cpu_ready), 64'd1);
                bv_m[s][blk] = 1'b1;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            tag_m[i] = -1;
            order.push_front(i);
            for (int b = 0; b < 64; b++) bv_m[i][b] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "ready", 64'(cpu_ready), 64'd1);
        chk("R1", "ack", 64'(cpu_ack), 64'd0);
        chk("R1", "mem_req", 64'(mem_req), 64'd0);
        // R1 R5 first read misses, takes sector 0
        access(0, 'h000108, 8, 0, 2, 1, "R1");
        // R2 hits in same block, including beat 7 and single byte
        access(0, 'h000100, 4, 0, 0, 0, "R2");
        access(0, 'h000138, 8, 0, 0, 0, "R2");
        access(0, 'h00013F, 1, 0, 0, 0, "R2");
        // R3 block miss in a present sector; older block stays valid
        access(0, 'h000FC0, 2, 0, 0, 0, "R3");
        access(0, 'h000100, 8, 0, 0, 0, "R3");
        // R4 requested doubleword is the last beat
        access(0, 'h0001F8, 8, 0, 3, 1, "R4");
        idle(2);
        // R6 rejected accesses
        access(0, 'h000105, 4, 0, 0, 0, "R6");
        access(0, 'h000100, 0, 0, 0, 0, "R6");
        access(0, 'h000100, 9, 0, 0, 0, "R6");
        access(1, 'h000107, 2, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R6");
        idle(1);
        access(0, 'h000100, 8, 0, 0, 0, "R6");
        // R7 R8 write to a valid block, then read hit sees merged bytes
        access(1, 'h000102, 2, 64'h1122_3344_5566_7788, 1, 0, "R7");
        access(0, 'h000100, 8, 0, 0, 0, "R8");
        access(1, 'h000FC0, 8, 64'hDEAD_BEEF_0BAD_F00D, 0, 0, "R7");
        access(0, 'h000FC4, 4, 0, 0, 0, "R8");
        // R8 write to an invalid block allocates nothing
        access(1, 'h000244, 4, 64'hCAFE_0000_1234_0000, 2, 0, "R8");
        access(0, 'h000240, 8, 0, 1, 0, "R8");
        // R5 fill remaining sectors, keep region 0 recent, then evict
        for (int k = 1; k < 8; k++) access(0, k * 'h1000 + 'h40, 8, 0, 0, 0, "R5");
        access(0, 'h000100, 8, 0, 0, 0, "R5");
        access(0, 'h008040, 8, 0, 1, 0, "R5");
        access(0, 'h001040, 8, 0, 0, 0, "R5");
        access(0, 'h000100, 8, 0, 0, 0, "R5");
        // R8 write to an absent region then read it
        access(1, 'h00A010, 8, 64'h0123_4567_89AB_CDEF, 0, 0, "R8");
        access(0, 'h00A010, 8, 0, 0, 1, "R8");
        // R5 push region 0 out, then its blocks must miss again
        for (int k = 11; k < 19; k++) access(0, k * 'h1000, 8, 0, 0, 0, "R5");
        access(0, 'h000FC0, 8, 0, 0, 0, "R5");
        access(0, 'h000100, 8, 0, 1, 0, "R5");
        access(0, 'h000104, 4, 0, 0, 0, "R2");
        idle(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule